// File: doc/BRIEF.md
# Gated Frequency Counter

This block measures the frequency of an intermediate-frequency signal by counting its rising edges over a fixed time window. One of two input signals is chosen by a select bit. Both inputs are resynchronised to the system clock, and the chosen one is halved by a toggle stage. Each completed pair of input edges adds one to a saturating counter, but only while the gate window is open.

A start strobe arms the block. The gate opens on the first reference tick after the strobe and stays open for 1, 4, 8 or 32 ticks, as set by a 2-bit code. With the usual 1 kHz tick, these are millisecond gates.

In normal mode each start clears the count and the prescaler phase. In integrating mode both are kept, so successive gates add to one running total. When the gate closes a done flag rises. The count can then be captured into a shift register and read out serially, most significant bit first.

Top module: `gated_freq_counter`

## Requirements
- R1: After reset, `count_o` is 0, `done_o` is 0 and `ser_o` is 0.
- R2: With `sel_i`=1 the block counts `gp_in_i`; with `sel_i`=0 it counts `alt_in_i`. The select is latched at start, and edges on the unselected input have no effect on `count_o`.
- R3: Inside an open gate, `count_o` rises by one for every second rising edge of the selected input, and by at most one per clock.
- R4: Gate code 0, 1, 2 and 3 keeps the gate open for 1, 4, 8 and 32 ticks after the opening tick. The gate closes on the last of these ticks, and later input edges leave `count_o` unchanged.
- R5: The gate opens on the first `tick_i` pulse after `start_i`. Input edges between the start and that tick are not counted.
- R6: A start with `integ_i`=0 clears `count_o` to 0 on the next cycle and resets the prescaler phase.
- R7: A start with `integ_i`=1 keeps both the count and the prescaler phase, so totals accumulate across gates. Outside a start, `count_o` never decreases.
- R8: `done_o` goes high in the cycle after the closing tick and goes low in the cycle after any start.
- R9: `count_o` holds at all ones instead of wrapping.
- R10: A pulse on `rd_load_i` captures `count_o`, and `ser_o` shows its MSB on the next cycle. Each `rd_shift_i` pulse then presents the next lower bit, and `rd_load_i` wins if both are high.
- R11: A start while a gate is armed or open abandons that gate and begins a new measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gp_in_i | input | 1 | Counter input, chosen when sel_i=1 |
| alt_in_i | input | 1 | Counter input, chosen when sel_i=0 |
| tick_i | input | 1 | Reference tick, one-cycle pulse |
| start_i | input | 1 | Measurement start strobe |
| sel_i | input | 1 | Input select |
| gate_code_i | input | 2 | Gate length code |
| integ_i | input | 1 | Integrating mode at start |
| rd_load_i | input | 1 | Capture count into serial register |
| rd_shift_i | input | 1 | Shift serial register by one bit |
| count_o | output | CNT_W (20) | Measured count |
| done_o | output | 1 | Gate finished |
| ser_o | output | 1 | Serial data, MSB first |

## Verification
The assertions assume three things about the inputs:
- A start is never accompanied by an input edge that reaches the counter in the same cycle.
- `tick_i` is a single-cycle pulse.
- The input edges are slow against the clock, with at least two cycles high and two cycles low.

The stimulus keeps every edge burst strictly between the opening and closing ticks, holds each input level for three clocks, and leaves a settling gap before each tick and each start. The gate lengths, modes and edge counts are randomised inside those limits, and the saturation case uses a narrower counter.

// File: rtl/fcnt_pkg.sv
package fcnt_pkg;
  localparam int TICK_W = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_OPEN} gate_st_e;

  function automatic logic [TICK_W-1:0] gate_len(input logic [1:0] code);
    case (code)
      2'd0:    return TICK_W'(1);
      2'd1:    return TICK_W'(4);
      2'd2:    return TICK_W'(8);
      default: return TICK_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/fcnt_edge_det.sv
module fcnt_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], in_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/fcnt_gate_timer.sv
module fcnt_gate_timer
  import fcnt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       tick_i,
  input  logic [1:0] code_i,
  output logic       gate_o,
  output logic       done_o
);
  gate_st_e          st_q;
  logic [TICK_W-1:0] cnt_q, len_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      len_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      // restart wins over any gate in progress
      st_q   <= ST_ARM;
      cnt_q  <= '0;
      len_q  <= gate_len(code_i);
      done_q <= 1'b0;
    end else begin
      case (st_q)
        ST_ARM: if (tick_i) begin
          st_q  <= ST_OPEN;
          cnt_q <= '0;
        end
        ST_OPEN: if (tick_i) begin
          if (cnt_q == len_q - TICK_W'(1)) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + TICK_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign gate_o = (st_q == ST_OPEN);
  assign done_o = done_q;
endmodule

// File: rtl/fcnt_accum.sv
module fcnt_accum #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             gate_i,
  input  logic             edge_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else if (clear_i) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else if (gate_i && edge_i) begin
      // divide by two: every second edge bumps the count
      phase_q <= ~phase_q;
      if (phase_q && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/fcnt_shift_out.sv
module fcnt_shift_out #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [CNT_W-1:0] par_i,
  output logic             ser_o
);
  logic [CNT_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= par_i;
    else if (shift_i) sh_q <= {sh_q[CNT_W-2:0], 1'b0};
  end

  assign ser_o = sh_q[CNT_W-1];
endmodule

// File: rtl/gated_freq_counter.sv
module gated_freq_counter #(
  parameter int CNT_W   = 20,
  parameter int SYNC_ST = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gp_in_i,
  input  logic             alt_in_i,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             sel_i,
  input  logic [1:0]       gate_code_i,
  input  logic             integ_i,
  input  logic             rd_load_i,
  input  logic             rd_shift_i,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o,
  output logic             ser_o
);
  localparam int N_IN = 2;

  logic [N_IN-1:0] raw_in, rise;
  logic            sel_q, gate, edge_sel;

  assign raw_in = {gp_in_i, alt_in_i};

  for (genvar g = 0; g < N_IN; g++) begin : g_in
    fcnt_edge_det #(.STAGES(SYNC_ST)) u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (raw_in[g]),
      .rise_o(rise[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= 1'b0;
    else if (start_i) sel_q <= sel_i;
  end

  assign edge_sel = rise[sel_q];

  fcnt_gate_timer u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .tick_i (tick_i),
    .code_i (gate_code_i),
    .gate_o (gate),
    .done_o (done_o)
  );

  fcnt_accum #(.CNT_W(CNT_W)) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(start_i & ~integ_i),
    .gate_i (gate),
    .edge_i (edge_sel),
    .count_o(count_o)
  );

  fcnt_shift_out #(.CNT_W(CNT_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (rd_load_i),
    .shift_i(rd_shift_i),
    .par_i  (count_o),
    .ser_o  (ser_o)
  );
endmodule

// File: rtl/fcnt_checker.sv
module fcnt_checker #(
  parameter int CNT_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             integ_i,
  input logic             rd_load_i,
  input logic [CNT_W-1:0] count_o,
  input logic             done_o,
  input logic             ser_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (count_o - $past(count_o)) <= CNT_W'(1)); // R3
  AST_HOLD_AFTER_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> $stable(count_o)); // R4
  AST_CLEAR_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !integ_i) |=> count_o == '0); // R6
  AST_NO_DECREASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> count_o >= $past(count_o)); // R7
  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == CNT_MAX && !start_i) |=> count_o == CNT_MAX); // R9
  AST_SER_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_load_i |=> ser_o == $past(count_o[CNT_W-1])); // R10
endmodule

bind gated_freq_counter fcnt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .integ_i  (integ_i),
  .rd_load_i(rd_load_i),
  .count_o  (count_o),
  .done_o   (done_o),
  .ser_o    (ser_o)
);

// File: tb/gated_freq_counter_tb.sv
module gated_freq_counter_tb;
  localparam int W = 10;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic gp_in = 0, alt_in = 0, tick = 0, start = 0, sel = 0, integ = 0;
  logic rd_load = 0, rd_shift = 0;
  logic [1:0] code = 0;
  logic [W-1:0] count;
  logic done, ser;

  int n_chk = 0, n_fail = 0;
  int total = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  gated_freq_counter #(.CNT_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .gp_in_i(gp_in), .alt_in_i(alt_in),
    .tick_i(tick), .start_i(start), .sel_i(sel), .gate_code_i(code),
    .integ_i(integ), .rd_load_i(rd_load), .rd_shift_i(rd_shift),
    .count_o(count), .done_o(done), .ser_o(ser)
  );

  function automatic int ticks_of(input int c);
    case (c) 0: return 1; 1: return 4; 2: return 8; default: return 32; endcase
  endfunction

  function automatic int expect_cnt();
    return (total / 2 > MAXV) ? MAXV : total / 2;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start(input bit s, input int c, input bit it);
    @(negedge clk);
    sel = s; code = 2'(c); integ = it; start = 1;
    @(negedge clk);
    start = 0;
    if (!it) total = 0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic pulses(input bit on_gp, input int n);
    for (int i = 0; i < n; i++) begin
      if (on_gp) gp_in = 1; else alt_in = 1;
      cyc(3);
      if (on_gp) gp_in = 0; else alt_in = 0;
      cyc(3);
    end
    cyc(4);
  endtask

  // one full measurement; counted edges land strictly inside the gate
  task automatic measure(input string req, input bit s, input int c, input bit it,
                         input int n_pre, input int n_sel, input int n_oth);
    do_start(s, c, it);
    pulses(s, n_pre);              // before opening tick: ignored (R5)
    do_tick();
    pulses(s, n_sel);
    pulses(!s, n_oth);             // unselected input (R2)
    total += n_sel;
    for (int i = 0; i < ticks_of(c) - 1; i++) do_tick();
    check({req, " R4 done low before last tick"}, int'(done), 0);
    do_tick();
    check({req, " R8 done after closing tick"}, int'(done), 1);
    check({req, " R3 count"}, int'(count), expect_cnt());
  endtask

  initial begin
    int unsigned r;
    r = $urandom(32'd2024);
    cyc(3);
    check("R1 count reset", int'(count), 0);
    check("R1 done reset", int'(done), 0);
    check("R1 ser reset", int'(ser), 0);
    rst_n = 1;
    cyc(2);

    measure("R2 gp", 1, 0, 0, 0, 7, 5);
    measure("R2 alt", 0, 1, 0, 3, 10, 9);
    measure("R5 pre-edges", 1, 2, 0, 6, 4, 0);
    measure("R4 long gate", 0, 3, 0, 0, 13, 2);

    // edges after close are ignored
    pulses(0, 6);
    check("R4 post-gate edges", int'(count), expect_cnt());

    // start clears count and done
    do_start(1, 0, 0);
    check("R6 clear", int'(count), 0);
    check("R8 done cleared", int'(done), 0);
    do_tick(); do_tick();

    // integrating: odd halves carry across gates
    measure("R7 integ a", 1, 0, 0, 0, 5, 0);
    measure("R7 integ b", 1, 1, 1, 0, 5, 1);
    check("R7 carried phase", int'(count), 5);

    // restart during open gate
    do_start(0, 1, 0);
    do_tick();
    pulses(0, 6);
    measure("R11 restart", 0, 0, 0, 0, 4, 0);

    // random mix
    for (int k = 0; k < 12; k++) begin
      r = $urandom;
      measure("R3 random", r[0], int'(r[2:1]), r[3], int'(r[7:4]) % 3,
              int'(r[13:8]) % 41, int'(r[19:16]) % 5);
    end

    // serial readout of a known value
    measure("R10 setup", 1, 0, 0, 0, 2 * 'h2D5 + 1, 0);
    @(negedge clk); rd_load = 1;
    @(negedge clk); rd_load = 0;
    for (int b = W - 1; b >= 0; b--) begin
      check("R10 serial bit", int'(ser), (expect_cnt() >> b) & 1);
      @(negedge clk); rd_shift = 1;
      @(negedge clk); rd_shift = 0;
    end

    // saturation
    measure("R9 saturate", 0, 0, 0, 0, 2 * MAXV + 60, 0);
    check("R9 at max", int'(count), MAXV);

    finished = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule